// File: doc/BRIEF.md
# Bus Error Injection Engine

This block injects a single, deliberate fault into the traffic that passes a bridge, so that error-recovery firmware can be tested. Firmware sets the engine up through a small register port. It writes a target address, an address mask, a target bus number and a four-bit error type, and then arms the engine. While the engine is armed, it compares every transaction seen on the monitor input against that setup. The first transaction that matches is corrupted in the same cycle, and the engine then disarms itself.

Corruption takes one of four forms:
- data bits are flipped in the pass-through data path;
- a single-cycle request to invert address parity;
- a single-cycle request to master-abort;
- a single-cycle request to target-abort.

The parity and ECC generators themselves sit outside this block and act on these controls. Only one setup exists, and all buses behind the bridge share it. Traffic that does not match always passes through untouched.

Top module: `errinj_engine`

## Requirements
- R1: After reset the engine is disarmed, the fired flag is 0, the control register reads 0, and no transaction is corrupted.
- R2: Register offsets: 0 = address low word, 1 = address high word, 2 = mask low word, 3 = mask high word, 4 = bus number (bits 7:0). Each register reads back what was written.
- R3: Offset 5 is control. A write stores the type in bits 3:0 and the wide-mode flag in bit 9. A write with bit 8 set and a valid type arms the engine and clears the fired flag. A write with bit 8 clear disarms the engine. A read returns the type in 3:0, wide mode in 9, armed in 16 and fired in 17, with all other bits 0.
- R4: The type is {class[3:2], kind[1:0]}. Class: 0 load, 1 store, 2 DMA read, 3 DMA write. Kind: 0 data parity, 1 address parity, 2 master abort, 3 target abort. Master abort and target abort on a load or a store are reserved: arming with a reserved type leaves the engine disarmed and leaves the fired flag unchanged.
- R5: A valid transaction matches when the engine is armed, its class equals the type's class, its bus equals the target bus, and every address bit that is not masked equals the target address. The corruption appears in the same cycle as the transaction.
- R6: In narrow mode (bit 9 = 0), only address bits 31:0 are compared, and only mask bits 23:0 take effect.
- R7: In wide mode, all 64 address bits are compared under the full 64-bit mask.
- R8: Each arm yields at most one injection. After an injection the engine is disarmed until it is armed again.
- R9: A data-parity injection inverts exactly data bits 0 and 1, which is at least two bits. All other data bits pass through, and unmatched data passes through unchanged.
- R10: An address-parity injection, a master-abort injection or a target-abort injection pulses only its own output for the matching cycle and leaves the data unchanged.
- R11: A transaction with a different bus or class is not corrupted, and the engine stays armed.
- R12: The fired flag sets on injection and stays set until the next successful arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mon_valid | input | 1 | Monitored transaction present |
| mon_op | input | 2 | Transaction class |
| mon_addr | input | 64 | Transaction address |
| mon_bus | input | 8 | Transaction bus number |
| mon_data | input | 64 | Transaction data |
| inj_data | output | 64 | Data after optional bit flips |
| inj_addr_par_flip | output | 1 | Invert address parity this cycle |
| inj_master_abort | output | 1 | Force master abort this cycle |
| inj_target_abort | output | 1 | Force target abort this cycle |

## Verification
The assertions watch several properties on every cycle:
- transactions on other buses pass through clean;
- a data injection flips exactly two bits;
- the engine disarms and sets fired after any injection;
- a reserved type never arms.

Some behaviours can only be shown by the bench's scenarios:
- the masking rules that differ between narrow mode and wide mode;
- the decoding of the class and kind in the type;
- register readback;
- that a second matching transaction after a shot is left alone.

// File: rtl/errinj_pkg.sv
package errinj_pkg;
    parameter int ADDR_W        = 64;
    parameter int DATA_W        = 64;
    parameter int BUS_W         = 8;
    parameter int REG_W         = 32;
    parameter int REG_AW        = 3;
    parameter int NARROW_ADDR_W = 32;
    parameter int NARROW_MASK_W = 24;

    localparam logic [REG_AW-1:0] OFS_ADDR_LO = 3'd0;
    localparam logic [REG_AW-1:0] OFS_ADDR_HI = 3'd1;
    localparam logic [REG_AW-1:0] OFS_MASK_LO = 3'd2;
    localparam logic [REG_AW-1:0] OFS_MASK_HI = 3'd3;
    localparam logic [REG_AW-1:0] OFS_BUS     = 3'd4;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 3'd5;

    localparam int CTL_ARM_BIT   = 8;
    localparam int CTL_WIDE_BIT  = 9;
    localparam int STS_ARMED_BIT = 16;
    localparam int STS_FIRED_BIT = 17;

    typedef enum logic [1:0] {OP_LOAD, OP_STORE, OP_DMA_RD, OP_DMA_WR} op_e;
    typedef enum logic [1:0] {K_DATA_PAR, K_ADDR_PAR, K_MABORT, K_TABORT} kind_e;

    typedef struct packed {
        op_e   op;
        kind_e kind;
    } etype_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mask;
        logic [BUS_W-1:0]  bus;
        etype_t            etype;
        logic              wide;
    } cfg_t;

    function automatic logic etype_ok(etype_t t);
        logic dma;
        dma = (t.op == OP_DMA_RD) || (t.op == OP_DMA_WR);
        return dma || (t.kind == K_DATA_PAR) || (t.kind == K_ADDR_PAR);
    endfunction
endpackage

// File: rtl/errinj_regs.sv
module errinj_regs
    import errinj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              fire,
    output cfg_t              cfg,
    output logic              armed,
    output logic              fired
);
    localparam int HALF = ADDR_W / 2;

    logic   ctl_wr;
    etype_t new_type;

    assign ctl_wr   = wr_en && (addr == OFS_CTRL);
    assign new_type = etype_t'(wdata[3:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            armed <= 1'b0;
            fired <= 1'b0;
        end else begin
            if (fire) begin
                armed <= 1'b0;
                fired <= 1'b1;
            end
            if (wr_en) begin
                case (addr)
                    OFS_ADDR_LO: cfg.addr[HALF-1:0]      <= wdata;
                    OFS_ADDR_HI: cfg.addr[ADDR_W-1:HALF] <= wdata;
                    OFS_MASK_LO: cfg.mask[HALF-1:0]      <= wdata;
                    OFS_MASK_HI: cfg.mask[ADDR_W-1:HALF] <= wdata;
                    OFS_BUS:     cfg.bus                 <= wdata[BUS_W-1:0];
                    OFS_CTRL: begin
                        cfg.etype <= new_type;
                        cfg.wide  <= wdata[CTL_WIDE_BIT];
                        if (wdata[CTL_ARM_BIT] && etype_ok(new_type)) begin
                            armed <= 1'b1;
                            fired <= 1'b0;
                        end else begin
                            armed <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_ADDR_LO: rdata = cfg.addr[HALF-1:0];
            OFS_ADDR_HI: rdata = cfg.addr[ADDR_W-1:HALF];
            OFS_MASK_LO: rdata = cfg.mask[HALF-1:0];
            OFS_MASK_HI: rdata = cfg.mask[ADDR_W-1:HALF];
            OFS_BUS:     rdata[BUS_W-1:0] = cfg.bus;
            OFS_CTRL: begin
                rdata[3:0]           = cfg.etype;
                rdata[CTL_WIDE_BIT]  = cfg.wide;
                rdata[STS_ARMED_BIT] = armed;
                rdata[STS_FIRED_BIT] = fired;
            end
            default: rdata = '0;
        endcase
    end

    // R4: a reserved type never leaves the engine armed
    p_reserved_rejected_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata[CTL_ARM_BIT] && !etype_ok(new_type)) |=> !armed);

    // R12: a successful arm clears the fired flag
    p_arm_clears_fired_r12: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata[CTL_ARM_BIT] && etype_ok(new_type)) |=> (armed && !fired));

    // R8: an injection disarms the engine and records it as fired
    p_shot_disarms_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && !ctl_wr) |=> (!armed && fired));

    // R1: the engine comes out of reset disarmed
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!armed && !fired));
endmodule

// File: rtl/errinj_match.sv
module errinj_match
    import errinj_pkg::*;
(
    input  cfg_t              cfg,
    input  logic              armed,
    input  logic              mon_valid,
    input  op_e               mon_op,
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic [BUS_W-1:0]  mon_bus,
    output logic              hit
);
    logic [ADDR_W-1:0] care;
    logic [ADDR_W-1:0] diff;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_care
        if (i < NARROW_MASK_W) begin : g_low
            assign care[i] = !cfg.mask[i];
        end else if (i < NARROW_ADDR_W) begin : g_mid
            assign care[i] = cfg.wide ? !cfg.mask[i] : 1'b1;
        end else begin : g_high
            assign care[i] = cfg.wide && !cfg.mask[i];
        end
    end

    assign diff = (mon_addr ^ cfg.addr) & care;
    assign hit  = armed && mon_valid
                  && (mon_bus == cfg.bus)
                  && (mon_op == cfg.etype.op)
                  && (diff == '0);
endmodule

// File: rtl/errinj_corrupt.sv
module errinj_corrupt
    import errinj_pkg::*;
#(
    parameter int FLIP_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  kind_e             kind,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              addr_par_flip,
    output logic              mabort,
    output logic              tabort
);
    logic [DATA_W-1:0] flip_pat;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pat
        assign flip_pat[i] = (i < FLIP_N);
    end

    assign dout          = (hit && kind == K_DATA_PAR) ? (din ^ flip_pat) : din;
    assign addr_par_flip = hit && (kind == K_ADDR_PAR);
    assign mabort        = hit && (kind == K_MABORT);
    assign tabort        = hit && (kind == K_TABORT);

    // R9: a data fault always flips at least two bits
    p_flip_count_r9: assert property (@(posedge clk) disable iff (rst)
        (hit && kind == K_DATA_PAR) |-> ($countones(dout ^ din) == FLIP_N && FLIP_N >= 2));

    // R10: only one fault form per injection
    p_single_form_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_par_flip, mabort, tabort, (dout != din)}));
endmodule

// File: rtl/errinj_engine.sv
module errinj_engine
    import errinj_pkg::*;
#(
    parameter int FLIP_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              mon_valid,
    input  logic [1:0]        mon_op,
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic [BUS_W-1:0]  mon_bus,
    input  logic [DATA_W-1:0] mon_data,
    output logic [DATA_W-1:0] inj_data,
    output logic              inj_addr_par_flip,
    output logic              inj_master_abort,
    output logic              inj_target_abort
);
    cfg_t cfg;
    logic armed;
    logic fired;
    logic hit;

    errinj_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .fire  (hit),
        .cfg   (cfg),
        .armed (armed),
        .fired (fired)
    );

    errinj_match u_match (
        .cfg       (cfg),
        .armed     (armed),
        .mon_valid (mon_valid),
        .mon_op    (op_e'(mon_op)),
        .mon_addr  (mon_addr),
        .mon_bus   (mon_bus),
        .hit       (hit)
    );

    errinj_corrupt #(.FLIP_N(FLIP_N)) u_corrupt (
        .clk           (clk),
        .rst           (rst),
        .hit           (hit),
        .kind          (cfg.etype.kind),
        .din           (mon_data),
        .dout          (inj_data),
        .addr_par_flip (inj_addr_par_flip),
        .mabort        (inj_master_abort),
        .tabort        (inj_target_abort)
    );

    // R11: another bus is never disturbed
    p_other_bus_clean_r11: assert property (@(posedge clk) disable iff (rst)
        (mon_bus != cfg.bus) |->
        (inj_data == mon_data && !inj_addr_par_flip && !inj_master_abort && !inj_target_abort));

    // R8: the cycle after a shot produces no further fault
    p_one_shot_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && !(reg_wr_en && reg_addr == OFS_CTRL)) |=>
        (inj_data == mon_data && !inj_addr_par_flip && !inj_master_abort && !inj_target_abort));

    // R12: fired stays set while disarmed and no control write arrives
    p_fired_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (fired && !(reg_wr_en && reg_addr == OFS_CTRL)) |=> fired);
endmodule

// File: tb/errinj_engine_tb_top.sv
module errinj_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mon_valid = 1'b0;
    logic [1:0]  mon_op = '0;
    logic [63:0] mon_addr = '0;
    logic [7:0]  mon_bus = '0;
    logic [63:0] mon_data = '0;
    logic [63:0] inj_data;
    logic        inj_addr_par_flip, inj_master_abort, inj_target_abort;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        logic [63:0] data;
        logic        ap, ma, ta;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [3:0] m_type;

    always #5 clk = ~clk;

    errinj_engine dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mon_valid(mon_valid), .mon_op(mon_op), .mon_addr(mon_addr), .mon_bus(mon_bus),
        .mon_data(mon_data), .inj_data(inj_data), .inj_addr_par_flip(inj_addr_par_flip),
        .inj_master_abort(inj_master_abort), .inj_target_abort(inj_target_abort)
    );

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 3'd5) m_type = d[3:0];
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #2;
        compared++;
        if (reg_rdata !== exp) begin
            mismatched++;
            $display("FAIL %s: reg %0d actual %h expected %h", tag, a, reg_rdata, exp);
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [1:0] op, input logic [63:0] a, input logic [7:0] bus,
                        input logic [63:0] d, input bit exp_hit, input string tag);
        exp_t e;
        e.data = d; e.ap = 0; e.ma = 0; e.ta = 0; e.tag = tag;
        if (exp_hit) begin
            case (m_type[1:0])
                2'd0: e.data = d ^ 64'h3;
                2'd1: e.ap = 1;
                2'd2: e.ma = 1;
                default: e.ta = 1;
            endcase
        end
        sb.push_back(e);
        mon_valid = 1'b1; mon_op = op; mon_addr = a; mon_bus = bus; mon_data = d;
        @(negedge clk);
        mon_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        #2;
        if (mon_valid) begin
            exp_t e;
            compared++;
            if (sb.size() == 0) begin
                mismatched++;
                $display("FAIL monitor: unexpected transaction, actual data %h expected none", inj_data);
            end else begin
                e = sb.pop_front();
                if (inj_data !== e.data || inj_addr_par_flip !== e.ap ||
                    inj_master_abort !== e.ma || inj_target_abort !== e.ta) begin
                    mismatched++;
                    $display("FAIL %s: actual data %h ap %b ma %b ta %b expected data %h ap %b ma %b ta %b",
                             e.tag, inj_data, inj_addr_par_flip, inj_master_abort, inj_target_abort,
                             e.data, e.ap, e.ma, e.ta);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        m_type = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd_check(3'd5, 32'h0, "R1 ctrl after reset");
        send(2'd0, 64'h0, 8'h0, 64'h1234, 0, "R1 disarmed no effect");

        // R2: configuration readback
        wr(3'd0, 32'h1234_5678);
        wr(3'd1, 32'hAAAA_0000);
        wr(3'd2, 32'h0000_00FF);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h5);
        rd_check(3'd0, 32'h1234_5678, "R2 addr lo");
        rd_check(3'd1, 32'hAAAA_0000, "R2 addr hi");
        rd_check(3'd2, 32'h0000_00FF, "R2 mask lo");
        rd_check(3'd4, 32'h5, "R2 bus");

        // R3: arm store data-parity, narrow
        wr(3'd5, 32'h104);
        rd_check(3'd5, 32'h0001_0004, "R3 armed readback");

        // R11: wrong bus, wrong class
        send(2'd1, 64'h0000_0000_1234_56AB, 8'h6, 64'hFF, 0, "R11 other bus");
        send(2'd0, 64'h0000_0000_1234_56AB, 8'h5, 64'hFF, 0, "R11 other class");
        // R5: unmasked address bit differs
        send(2'd1, 64'h0000_0000_1234_5778, 8'h5, 64'hFF, 0, "R5 addr mismatch");
        // R6 / R9: upper bits ignored in narrow mode; data flip
        send(2'd1, 64'hFFFF_FFFF_1234_5600, 8'h5, 64'hFFFF_0000_1234_5678, 1, "R6 R9 narrow hit");
        // R8: second match ignored
        send(2'd1, 64'hFFFF_FFFF_1234_5600, 8'h5, 64'h0F0F, 0, "R8 one shot");
        rd_check(3'd5, 32'h0002_0004, "R12 fired sticky");

        // R4: reserved type rejected
        wr(3'd5, 32'h102);
        rd_check(3'd5, 32'h0002_0002, "R4 reserved not armed");
        send(2'd0, 64'h1234_5678, 8'h5, 64'h77, 0, "R4 no injection");

        // R6: narrow mask bits above 23 ignored; R10 target abort
        wr(3'd2, 32'hFF00_0000);
        wr(3'd5, 32'h10F);
        rd_check(3'd5, 32'h0001_000F, "R12 re-arm clears fired");
        send(2'd3, 64'h0000_0000_1334_5678, 8'h5, 64'h55, 0, "R6 high mask ignored");
        send(2'd3, 64'h0000_0000_1234_5678, 8'h5, 64'h55, 1, "R10 target abort");

        // R7: wide mode
        wr(3'd1, 32'h0000_00C0);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0F00_0000);
        wr(3'd5, 32'h30A);
        send(2'd2, 64'h0000_01C0_0000_0000, 8'h5, 64'h99, 0, "R7 upper bit compared");
        send(2'd2, 64'h0300_00C0_DEAD_BEEF, 8'h5, 64'h99, 1, "R7 R10 master abort");

        // R10: address parity
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd5, 32'h109);
        send(2'd2, 64'h5555_5555_1234_5678, 8'h5, 64'hABCD, 1, "R10 addr parity");

        // R3: explicit disarm
        wr(3'd5, 32'h108);
        wr(3'd5, 32'h008);
        rd_check(3'd5, 32'h0000_0008, "R3 disarm readback");
        send(2'd2, 64'h1234_5678, 8'h5, 64'h1, 0, "R3 disarmed no effect");

        // R9: data parity on DMA read
        wr(3'd5, 32'h108);
        send(2'd2, 64'h1234_5678, 8'h5, 64'h0, 1, "R9 two bit flip");
        rd_check(3'd5, 32'h0002_0008, "R12 fired after DMA");

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule